// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block adds two unsigned WIDTH-bit operands and a carry input, and returns a WIDTH-bit sum with a carry output. The operand bits are cut into slices that grow in width from the least significant end. The bottom slice is a ripple-carry adder fed straight from the carry input. Every higher slice ripples its bits once, assuming an incoming carry of zero. It then forms the "incoming carry of one" answer by adding one to that result, instead of rippling a second time. A two-way selector driven by the carry out of the slice below picks between the two answers.

At 16 bits the slices are 2, 2, 3, 4 and 5 bits wide, from least to most significant. The same rule applies at any width. The first two slices are 2 bits wide, each later slice is one bit wider than the one before, and the last slice is cut short to the bits that remain. For 8 bits this gives 2, 2, 3 and 1. An output register can be switched on by a parameter to close timing. It is on by default, and with it the result appears one clock after the operands.

Top module: `sqrt_csel_adder`

## Requirements
- R1: The pair {cout, sum} equals the (WIDTH+1)-bit value of a + b + cin, with cout as the most significant bit.
- R2: A carry that starts in the lowest bit crosses every slice boundary. The case a = 2^k-1, b = 1, cin = 0 gives sum = 2^k and cout = 0 for k < WIDTH. All-ones a with b = 0 and cin = 1 gives sum = 0 and cout = 1.
- R3: With b = 0 and cin = 0, sum equals a and cout is 0. The add-one path never leaks into a result whose select is 0.
- R4: cout is 1 exactly when a + b + cin is at least 2^WIDTH. Whenever cout is 1, sum is no greater than a.
- R5: With the output register on (OUT_REG = 1), the result of the operands present at a rising clock edge is visible after that edge. A synchronous active-high rst drives sum and cout to zero at the next edge.
- R6: With the output register off (OUT_REG = 0), sum and cout follow the operands combinationally, with no clock involved.
- R7: The adder is correct at WIDTH = 8, 16, 32 and 64, using the slice-width rule stated above.
- R8: All-ones a plus all-ones b plus cin = 1 gives an all-ones sum and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The properties assume that a, b and cin are known values, free of X, at every rising edge outside reset. The registered variant also relies on the operands being stable across the edge at which they are captured. The stimulus drives every input to zero from time zero and changes operands only on falling clock edges, so each sampled edge sees settled, defined values. No property is evaluated while rst is high. The reset check waits until the operands have already been applied and then looks at the outputs only.

// File: rtl/csa_pkg.sv
package csa_pkg;

    localparam int FIRST_SLICE_W = 2;

    typedef struct packed {
        logic c;
        logic s;
    } fa_t;

    function automatic fa_t full_add(input logic x, input logic y, input logic ci);
        fa_t r;
        r.s = x ^ y ^ ci;
        r.c = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

    function automatic int nominal_w(input int g);
        return (g == 0) ? FIRST_SLICE_W : g + 1;
    endfunction

    function automatic int clip_w(input int g, input int remaining);
        int nw;
        nw = nominal_w(g);
        return (nw < remaining) ? nw : remaining;
    endfunction

    function automatic int slice_lo(input int n, input int g);
        int lo;
        lo = 0;
        for (int j = 0; j < g; j++) begin
            if (lo < n) lo = lo + clip_w(j, n - lo);
        end
        return lo;
    endfunction

    function automatic int slice_w(input int n, input int g);
        int lo;
        lo = slice_lo(n, g);
        if (lo >= n) return 0;
        return clip_w(g, n - lo);
    endfunction

    function automatic int slice_count(input int n);
        int lo;
        int cnt;
        lo = 0;
        cnt = 0;
        for (int j = 0; j < n; j++) begin
            if (lo < n) begin
                lo = lo + clip_w(j, n - lo);
                cnt = cnt + 1;
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int K = 4
) (
    input  logic [K-1:0] x,
    input  logic [K-1:0] y,
    input  logic         ci,
    output logic [K:0]   s
);
    logic [K:0] chain;
    assign chain[0] = ci;

    for (genvar i = 0; i < K; i++) begin : g_bit
        csa_pkg::fa_t fo;
        assign fo          = csa_pkg::full_add(x[i], y[i], chain[i]);
        assign s[i]        = fo.s;
        assign chain[i+1]  = fo.c;
    end

    assign s[K] = chain[K];
endmodule

// File: rtl/csa_excess1.sv
module csa_excess1 #(
    parameter int K = 4
) (
    input  logic [K:0] d,
    output logic [K:0] q
);
    logic [K+1:0] below_ones;
    assign below_ones[0] = 1'b1;

    for (genvar i = 0; i <= K; i++) begin : g_bit
        assign below_ones[i+1] = below_ones[i] & d[i];
        assign q[i]            = d[i] ^ below_ones[i];
    end
endmodule

// File: rtl/csa_slice.sv
module csa_slice #(
    parameter int K = 4
) (
    input  logic [K-1:0] x,
    input  logic [K-1:0] y,
    input  logic         sel,
    output logic [K:0]   r
);
    logic [K:0] zero_in;
    logic [K:0] one_in;

    csa_ripple #(.K(K)) u_rip (
        .x  (x),
        .y  (y),
        .ci (1'b0),
        .s  (zero_in)
    );

    csa_excess1 #(.K(K)) u_inc (
        .d (zero_in),
        .q (one_in)
    );

    assign r = sel ? one_in : zero_in;
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NSLICE = csa_pkg::slice_count(WIDTH);

    logic [NSLICE:0]  link;
    logic [WIDTH-1:0] sum_c;

    assign link[0] = cin;

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        localparam int LO = csa_pkg::slice_lo(WIDTH, g);
        localparam int SW = csa_pkg::slice_w(WIDTH, g);
        logic [SW:0] res;

        if (g == 0) begin : g_base
            csa_ripple #(.K(SW)) u_base (
                .x  (a[LO +: SW]),
                .y  (b[LO +: SW]),
                .ci (link[0]),
                .s  (res)
            );
        end else begin : g_sel
            csa_slice #(.K(SW)) u_sl (
                .x   (a[LO +: SW]),
                .y   (b[LO +: SW]),
                .sel (link[g]),
                .r   (res)
            );
        end

        assign sum_c[LO +: SW] = res[SW-1:0];
        assign link[g+1]       = res[SW];
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sum  <= '0;
                cout <= 1'b0;
            end else begin
                sum  <= sum_c;
                cout <= link[NSLICE];
            end
        end
    end else begin : g_comb
        assign sum  = sum_c;
        assign cout = link[NSLICE];
    end
endmodule

// File: rtl/csa_checker.sv
module csa_checker #(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    logic [WIDTH:0]   now_total;
    logic             now_inc, now_ident, now_max;
    logic [WIDTH:0]   exp_total;
    logic [WIDTH-1:0] exp_a;
    logic             exp_inc, exp_ident, exp_max, live;

    assign now_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    assign now_inc   = (a == '1) && (b == '0) && cin;
    assign now_ident = (b == '0) && !cin;
    assign now_max   = (a == '1) && (b == '1) && cin;

    if (OUT_REG) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst) begin
                live      <= 1'b0;
                exp_total <= '0;
                exp_a     <= '0;
                exp_inc   <= 1'b0;
                exp_ident <= 1'b0;
                exp_max   <= 1'b0;
            end else begin
                live      <= 1'b1;
                exp_total <= now_total;
                exp_a     <= a;
                exp_inc   <= now_inc;
                exp_ident <= now_ident;
                exp_max   <= now_max;
            end
        end

        // R5: outputs cleared by reset
        p_reset_clear_r5: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (sum == '0) && !cout);
    end else begin : g_now
        assign live      = 1'b1;
        assign exp_total = now_total;
        assign exp_a     = a;
        assign exp_inc   = now_inc;
        assign exp_ident = now_ident;
        assign exp_max   = now_max;
    end

    p_total_r1: assert property (@(posedge clk) disable iff (rst)
        live |-> ({cout, sum} == exp_total));

    p_ripple_through_r2: assert property (@(posedge clk) disable iff (rst)
        (live && exp_inc) |-> (sum == '0) && cout);

    p_identity_r3: assert property (@(posedge clk) disable iff (rst)
        (live && exp_ident) |-> (sum == exp_a) && !cout);

    p_wrap_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (live && cout) |-> (sum <= exp_a));

    p_max_r8: assert property (@(posedge clk) disable iff (rst)
        (live && exp_max) |-> (sum == '1) && cout);
endmodule

bind sqrt_csel_adder csa_checker #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/sqrt_csel_adder_bench.sv
`timescale 1ns/1ps
module sqrt_csel_adder_bench;

    typedef struct {
        logic [8:0]  e8;
        logic [16:0] e16;
        logic [32:0] e32;
        logic [64:0] e64;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a_in = '0;
    logic [63:0] b_in = '0;
    logic        c_in = 1'b0;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    item_t       sb[$];

    logic [7:0]  s8;  logic co8;
    logic [15:0] s16; logic co16;
    logic [31:0] s32; logic co32;
    logic [63:0] s64; logic co64;
    logic [15:0] sc16; logic coc16;

    always #2.5 clk = ~clk;

    sqrt_csel_adder #(.WIDTH(16), .OUT_REG(1'b1)) u_sqrt_csel_adder (
        .clk(clk), .rst(rst), .a(a_in[15:0]), .b(b_in[15:0]), .cin(c_in), .sum(s16), .cout(co16));
    sqrt_csel_adder #(.WIDTH(8), .OUT_REG(1'b1)) u_w8 (
        .clk(clk), .rst(rst), .a(a_in[7:0]), .b(b_in[7:0]), .cin(c_in), .sum(s8), .cout(co8));
    sqrt_csel_adder #(.WIDTH(32), .OUT_REG(1'b1)) u_w32 (
        .clk(clk), .rst(rst), .a(a_in[31:0]), .b(b_in[31:0]), .cin(c_in), .sum(s32), .cout(co32));
    sqrt_csel_adder #(.WIDTH(64), .OUT_REG(1'b1)) u_w64 (
        .clk(clk), .rst(rst), .a(a_in), .b(b_in), .cin(c_in), .sum(s64), .cout(co64));
    sqrt_csel_adder #(.WIDTH(16), .OUT_REG(1'b0)) u_comb16 (
        .clk(clk), .rst(rst), .a(a_in[15:0]), .b(b_in[15:0]), .cin(c_in), .sum(sc16), .cout(coc16));

    task automatic check(input string tag, input string what,
                         input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [63:0] a, input logic [63:0] b,
                         input logic c, input string tag);
        item_t it;
        @(negedge clk);
        a_in = a;
        b_in = b;
        c_in = c;
        it.e8  = {1'b0, a[7:0]}  + {1'b0, b[7:0]}  + {8'd0, c};
        it.e16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, c};
        it.e32 = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'd0, c};
        it.e64 = {1'b0, a}       + {1'b0, b}       + {64'd0, c};
        it.tag = tag;
        sb.push_back(it);
        #1;
        // R6: combinational variant follows the operands
        check("R6", "comb16", {48'd0, coc16, sc16}, {48'd0, it.e16});
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(it.tag, "w8",  {56'd0, co8, s8},   {56'd0, it.e8});
                check(it.tag, "w16", {48'd0, co16, s16}, {48'd0, it.e16});
                check(it.tag, "w32", {32'd0, co32, s32}, {32'd0, it.e32});
                check(it.tag, "w64", {co64, s64},        it.e64);
            end
        end
    end

    task automatic drain();
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired before completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: reset state of the registered outputs
        check("R5", "reset w16", {48'd0, co16, s16}, '0);
        check("R5", "reset w64", {co64, s64}, '0);
        rst = 1'b0;

        // R1 and R7: every 8-bit operand pair, random upper bits
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                drive({$urandom, $urandom(), 24'd0, 8'(i)} | 64'(i),
                      {$urandom, $urandom(), 24'd0, 8'(j)} | 64'(j),
                      1'(($urandom >> 3) & 1), "R1");
            end
        end

        // R2: carries that run across every slice boundary
        drive('1, '0, 1'b1, "R2");
        for (int k = 1; k < 64; k++) drive((64'd1 << k) - 64'd1, 64'd1, 1'b0, "R2");

        // R3: identity with zero addend and no carry in
        for (int k = 0; k < 50; k++) drive({$urandom, $urandom}, '0, 1'b0, "R3");

        // R4: large operands, carry out decided near the top
        for (int k = 0; k < 200; k++)
            drive(~64'({$urandom} & 32'hff), {$urandom, $urandom}, 1'(k & 1), "R4");
        drive(64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff, 1'b1, "R4");
        drive(64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff, 1'b0, "R4");

        // R8: largest possible sum
        drive('1, '1, 1'b1, "R8");

        // R7: random operands at all widths
        for (int k = 0; k < 2000; k++)
            drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom & 1), "R7");

        drain();

        // R5: synchronous reset in mid-run with nonzero operands applied
        a_in = 64'h1234_5678_9abc_def0;
        b_in = 64'hffff_0000_ffff_0000;
        c_in = 1'b1;
        rst  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R5", "midrun reset w16", {48'd0, co16, s16}, '0);
        check("R5", "midrun reset w32", {32'd0, co32, s32}, '0);
        rst = 1'b0;
        drive(64'd5, 64'd7, 1'b1, "R5");
        drain();

        finish_run();
    end
endmodule